// File: doc/BRIEF.md
# Way-Masked Cache Allocation Controller

This block holds the tags, line data and replacement state of a small set-associative cache that several masters share, and decides where a write miss may land. One global register names the ways that may be used at all; each master has its own mask register whose set bits keep that master from allocating into, and so evicting, the matching ways. A write miss picks its victim by a per-set round-robin pointer among the ways that are enabled and not masked for the requester. Lookups ignore both registers, so a line stays reachable by every master whatever the masks say.

An address window with no memory behind it can be cached like any other address. It serves as a scratchpad: a master fills it through an allocation path that only reaches the ways it should, then the masks are closed so that nobody evicts those ways. A line from the window that is evicted anyway is discarded and reported on a drop port, never written back. Each request is answered one cycle later, together with any writeback or drop it caused.

Top module: `wm_alloc_ctrl`

## Requirements
- R1: After reset every way is enabled, every mask is clear and every line is invalid, so a first read misses with rsp_rdata zero and no writeback or drop.
- R2: A request sampled at a clock edge gives rsp_valid high for exactly the following cycle, with rsp_hit, rsp_alloc, rsp_noalloc, rsp_way and rsp_rdata for that request.
- R3: A write miss allocates into the first candidate way at or after the set's round-robin pointer (wrapping), candidates being enable AND NOT mask of the requesting master; the pointer then moves to the victim plus one. Pointers reset to way 0.
- R4: A way whose bit is clear in the enable register never receives a new allocation.
- R5: A way whose bit is set in a master's mask never receives an allocation from that master; other masters are unaffected.
- R6: Hits are detected in every valid way regardless of enable and mask; a read hit returns the line data and a write hit updates it, without allocating.
- R7: A write miss with no candidate way sets rsp_noalloc and allocates nothing; a normal-address write is then forwarded on the writeback port and a scratchpad write is reported on the drop port.
- R8: A read miss never allocates and returns zero data, including reads from the scratchpad window.
- R9: Evicting a line whose address is outside the scratchpad window raises wb_valid with that line's word address and data in the response cycle.
- R10: Evicting a line from the scratchpad window raises drop_valid with its address and never wb_valid; the window is [SPAD_BASE, SPAD_BASE+SPAD_BYTES).
- R11: A register write takes effect from the next cycle; a request in the same cycle as a mask write uses the old mask.
- R12: cfg_mask_sel=0 writes cfg_wdata to the enable register; cfg_mask_sel=1 writes it to the mask of master cfg_master. Bit n of either register refers to way n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_mask_sel | input | 1 | 0 selects enable register, 1 selects a master mask |
| cfg_master | input | clog2(NMASTERS) | Master whose mask is written |
| cfg_wdata | input | NWAYS | Register write value, one bit per way |
| req_valid | input | 1 | Request present |
| req_master | input | clog2(NMASTERS) | Requesting master |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte address; bits [1:0] ignored for lookup |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit a valid line |
| rsp_alloc | output | 1 | A line was allocated |
| rsp_noalloc | output | 1 | Write miss found no candidate way |
| rsp_way | output | clog2(NWAYS) | Way hit or allocated |
| rsp_rdata | output | DW | Read data, zero on a miss |
| wb_valid | output | 1 | Write to memory required |
| wb_addr | output | AW | Writeback address |
| wb_data | output | DW | Writeback data |
| drop_valid | output | 1 | Scratchpad data discarded |
| drop_addr | output | AW | Address of discarded data |

## Verification
The hardest state to reach is a scratchpad line being pushed out of the cache, since the masks normally exist to stop exactly that. The bench narrows one master's candidate set to a single way, fills it with a scratchpad line and then writes a second scratchpad tag to the same set, so that the round-robin pointer wraps back onto the occupied way and forces the eviction. The same narrowing, taken to an empty set and combined with a mask write in the very cycle of a request, shows the old-mask rule and the no-allocate path.

// File: rtl/wm_alloc_ctrl.sv
module wm_alloc_ctrl #(
  parameter int NWAYS = 8,
  parameter int NSETS = 16,
  parameter int NMASTERS = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [31:0] SPAD_BASE = 32'h0800_0000,
  parameter logic [31:0] SPAD_BYTES = 32'h0001_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_mask_sel,
  input  logic [$clog2(NMASTERS)-1:0] cfg_master,
  input  logic [NWAYS-1:0]            cfg_wdata,
  input  logic                        req_valid,
  input  logic [$clog2(NMASTERS)-1:0] req_master,
  input  logic                        req_write,
  input  logic [AW-1:0]               req_addr,
  input  logic [DW-1:0]               req_wdata,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_alloc,
  output logic                        rsp_noalloc,
  output logic [$clog2(NWAYS)-1:0]    rsp_way,
  output logic [DW-1:0]               rsp_rdata,
  output logic                        wb_valid,
  output logic [AW-1:0]               wb_addr,
  output logic [DW-1:0]               wb_data,
  output logic                        drop_valid,
  output logic [AW-1:0]               drop_addr
);
  localparam int WW  = $clog2(NWAYS);
  localparam int SW  = $clog2(NSETS);
  localparam int OFS = 2;
  localparam int TW  = AW - SW - OFS;

  logic [NWAYS-1:0]                 en_q;
  logic [NMASTERS-1:0][NWAYS-1:0]   mask_q;
  logic [NWAYS-1:0]                 vld_q [NSETS];
  logic [WW-1:0]                    ptr_q [NSETS];
  logic [TW-1:0]                    tag_q [NSETS][NWAYS];
  logic [DW-1:0]                    dat_q [NSETS][NWAYS];

  function automatic logic in_win(input logic [AW-1:0] a);
    return (a >= AW'(SPAD_BASE)) && ((a - AW'(SPAD_BASE)) < AW'(SPAD_BYTES));
  endfunction

  wire [SW-1:0] set = req_addr[OFS+SW-1:OFS];
  wire [TW-1:0] tag = req_addr[AW-1:OFS+SW];
  wire [NWAYS-1:0] cand = en_q & ~mask_q[req_master];

  logic [NWAYS-1:0] hit_vec;
  logic [WW-1:0]    hit_way;
  logic [WW-1:0]    victim;
  logic             found;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      hit_vec[w] = vld_q[set][w] && (tag_q[set][w] == tag);
      if (hit_vec[w]) hit_way = WW'(w);
    end
  end

  always_comb begin
    logic [WW-1:0] idx;
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < NWAYS; i++) begin
      idx = ptr_q[set] + WW'(i);
      if (!found && cand[idx]) begin
        victim = idx;
        found  = 1'b1;
      end
    end
  end

  wire hit      = |hit_vec;
  wire wr_miss  = req_valid && req_write && !hit;
  wire do_alloc = wr_miss && found;
  wire no_alloc = wr_miss && !found;
  wire req_spad = in_win(req_addr);
  wire vic_vld  = vld_q[set][victim];
  wire [AW-1:0] vic_addr = {tag_q[set][victim], set, {OFS{1'b0}}};
  wire vic_spad = in_win(vic_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '1;
      mask_q <= '0;
    end else if (cfg_we) begin
      if (cfg_mask_sel) mask_q[cfg_master] <= cfg_wdata;
      else              en_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else if (do_alloc) begin
      vld_q[set][victim] <= 1'b1;
      ptr_q[set]         <= victim + WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      tag_q[set][victim] <= tag;
      dat_q[set][victim] <= req_wdata;
    end else if (req_valid && req_write && hit) begin
      dat_q[set][hit_way] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_alloc   <= 1'b0;
      rsp_noalloc <= 1'b0;
      rsp_way     <= '0;
      rsp_rdata   <= '0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
      wb_data     <= '0;
      drop_valid  <= 1'b0;
      drop_addr   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= req_valid && hit;
      rsp_alloc   <= do_alloc;
      rsp_noalloc <= no_alloc;
      rsp_way     <= hit ? hit_way : victim;
      rsp_rdata   <= (req_valid && !req_write && hit) ? dat_q[set][hit_way] : '0;
      wb_valid    <= (do_alloc && vic_vld && !vic_spad) || (no_alloc && !req_spad);
      wb_addr     <= no_alloc ? req_addr : vic_addr;
      wb_data     <= no_alloc ? req_wdata : dat_q[set][victim];
      drop_valid  <= (do_alloc && vic_vld && vic_spad) || (no_alloc && req_spad);
      drop_addr   <= no_alloc ? req_addr : vic_addr;
    end
  end
endmodule

module wm_alloc_ctrl_chk #(
  parameter int NWAYS = 8,
  parameter int NMASTERS = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [31:0] SPAD_BASE = 32'h0800_0000,
  parameter logic [31:0] SPAD_BYTES = 32'h0001_0000
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [$clog2(NMASTERS)-1:0] req_master,
  input logic [NWAYS-1:0]            en_q,
  input logic [NMASTERS-1:0][NWAYS-1:0] mask_q,
  input logic                        rsp_valid,
  input logic                        rsp_hit,
  input logic                        rsp_alloc,
  input logic                        rsp_noalloc,
  input logic [$clog2(NWAYS)-1:0]    rsp_way,
  input logic [DW-1:0]               rsp_rdata,
  input logic                        wb_valid,
  input logic [AW-1:0]               wb_addr,
  input logic                        drop_valid
);
  logic [NWAYS-1:0] past_cand;
  logic             past_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_cand <= '0;
      past_req  <= 1'b0;
    end else begin
      past_cand <= en_q & ~mask_q[req_master];
      past_req  <= req_valid;
    end
  end

  wire wb_in_win = (wb_addr >= AW'(SPAD_BASE)) && ((wb_addr - AW'(SPAD_BASE)) < AW'(SPAD_BYTES));

  // R2
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == past_req);
  // R3
  alloc_in_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_alloc |-> past_cand[rsp_way]);
  // R7
  noalloc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_noalloc |-> (past_cand == '0 && !rsp_alloc && !rsp_hit));
  // R6
  hit_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !rsp_alloc && !rsp_noalloc);
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_rdata == '0);
  // R10
  spad_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !wb_in_win);
  // R9
  wb_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && drop_valid));
endmodule

bind wm_alloc_ctrl wm_alloc_ctrl_chk #(
  .NWAYS(NWAYS), .NMASTERS(NMASTERS), .AW(AW), .DW(DW),
  .SPAD_BASE(SPAD_BASE), .SPAD_BYTES(SPAD_BYTES)
) chk_i (.*);

// File: tb/wm_alloc_ctrl_tb.sv
`timescale 1ns/1ps
module wm_alloc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_mask_sel = 1'b0;
  logic [1:0] cfg_master = '0;
  logic [7:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_master = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_hit, rsp_alloc, rsp_noalloc, wb_valid, drop_valid;
  logic [2:0] rsp_way;
  logic [31:0] rsp_rdata, wb_addr, wb_data, drop_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic r_hit, r_alloc, r_noalloc, r_wb, r_drop;
  logic [2:0] r_way;
  logic [31:0] r_rdata, r_wba, r_wbd, r_dropa;

  always #10 clk = ~clk;

  wm_alloc_ctrl dut_i (.*);

  function automatic logic [31:0] na(input int s, input int t);
    return 32'h1000_0000 + 32'(t * 64) + 32'(s * 4);
  endfunction
  function automatic logic [31:0] sa(input int s, input int t);
    return 32'h0800_0000 + 32'(t * 64) + 32'(s * 4);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic capture();
    r_hit = rsp_hit; r_alloc = rsp_alloc; r_noalloc = rsp_noalloc; r_way = rsp_way;
    r_rdata = rsp_rdata; r_wb = wb_valid; r_wba = wb_addr; r_wbd = wb_data;
    r_drop = drop_valid; r_dropa = drop_addr;
  endtask

  task automatic req(input int m, input logic [31:0] a, input logic w, input logic [31:0] d,
                     input bit with_cfg = 0, input logic msel = 0, input int cm = 0,
                     input logic [7:0] cd = 0);
    @(negedge clk);
    req_valid = 1; req_master = m[1:0]; req_addr = a; req_write = w; req_wdata = d;
    if (with_cfg) begin
      cfg_we = 1; cfg_mask_sel = msel; cfg_master = cm[1:0]; cfg_wdata = cd;
    end
    @(negedge clk);
    chk("R2 rsp_valid", 32'(rsp_valid), 1);
    capture();
    req_valid = 0; cfg_we = 0;
  endtask

  task automatic cfg(input logic msel, input int m, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_mask_sel = msel; cfg_master = m[1:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset();
    req(0, na(0, 0), 0, 0);
    chk("R1 hit after reset", 32'(r_hit), 0);
    chk("R1 R8 rdata zero", r_rdata, 0);
    chk("R1 no wb", 32'(r_wb), 0);
    chk("R1 no drop", 32'(r_drop), 0);
    chk("R8 no alloc on read miss", 32'(r_alloc), 0);
  endtask

  task automatic t_round_robin();
    for (int k = 0; k < 8; k++) begin
      req(0, na(0, k), 1, 32'hA000_0000 + 32'(k));
      chk("R3 alloc", 32'(r_alloc), 1);
      chk("R3 way order", 32'(r_way), 32'(k));
      chk("R9 no wb on invalid victim", 32'(r_wb), 0);
    end
    req(0, na(0, 8), 1, 32'hA000_0008);
    chk("R3 wrap way", 32'(r_way), 0);
    chk("R9 wb valid", 32'(r_wb), 1);
    chk("R9 wb addr", r_wba, na(0, 0));
    chk("R9 wb data", r_wbd, 32'hA000_0000);
    req(2, na(0, 3), 0, 0);
    chk("R6 read hit", 32'(r_hit), 1);
    chk("R6 read way", 32'(r_way), 3);
    chk("R6 read data", r_rdata, 32'hA000_0003);
  endtask

  task automatic t_enable();
    cfg(0, 0, 8'hF0);
    req(0, na(1, 0), 1, 32'h1);
    chk("R4 R12 first enabled way", 32'(r_way), 4);
    req(0, na(1, 1), 1, 32'h2);
    chk("R4 next enabled way", 32'(r_way), 5);
    cfg(0, 0, 8'hFF);
  endtask

  task automatic t_mask();
    cfg(1, 1, 8'h0F);
    req(0, na(2, 0), 1, 32'hB0);
    chk("R5 unmasked master way", 32'(r_way), 0);
    req(1, na(2, 1), 1, 32'hB1);
    chk("R5 R12 masked master skips", 32'(r_way), 4);
    req(1, na(2, 0), 0, 0);
    chk("R6 masked way still hit", 32'(r_hit), 1);
    chk("R6 masked way data", r_rdata, 32'hB0);
    req(1, na(2, 0), 1, 32'hB2);
    chk("R6 write hit masked way", 32'(r_hit), 1);
    chk("R6 write hit no alloc", 32'(r_alloc), 0);
    req(3, na(2, 0), 0, 0);
    chk("R6 updated data", r_rdata, 32'hB2);
    cfg(1, 1, 8'h00);
  endtask

  task automatic t_empty();
    cfg(1, 1, 8'hFF);
    req(1, na(3, 0), 1, 32'hC0);
    chk("R7 noalloc", 32'(r_noalloc), 1);
    chk("R7 no alloc", 32'(r_alloc), 0);
    chk("R7 forwarded wb", 32'(r_wb), 1);
    chk("R7 forwarded addr", r_wba, na(3, 0));
    chk("R7 forwarded data", r_wbd, 32'hC0);
    req(1, sa(3, 0), 1, 32'hC1);
    chk("R7 spad noalloc", 32'(r_noalloc), 1);
    chk("R7 spad drop", 32'(r_drop), 1);
    chk("R7 spad drop addr", r_dropa, sa(3, 0));
    chk("R7 spad no wb", 32'(r_wb), 0);
    req(0, na(3, 0), 0, 0);
    chk("R7 nothing allocated", 32'(r_hit), 0);
    cfg(1, 1, 8'h00);
  endtask

  task automatic t_spad_evict();
    cfg(1, 0, 8'hFE);
    req(0, sa(4, 0), 1, 32'hD0);
    chk("R10 spad alloc way0", 32'(r_way), 0);
    req(0, sa(4, 1), 1, 32'hD1);
    chk("R10 drop", 32'(r_drop), 1);
    chk("R10 drop addr", r_dropa, sa(4, 0));
    chk("R10 no wb", 32'(r_wb), 0);
    req(0, sa(4, 0), 0, 0);
    chk("R8 spad miss zero", r_rdata, 0);
    chk("R8 spad miss", 32'(r_hit), 0);
    req(0, na(4, 2), 1, 32'hD2);
    chk("R10 normal evicts spad drop", r_dropa, sa(4, 1));
    req(0, na(4, 3), 1, 32'hD3);
    chk("R9 normal evict wb", 32'(r_wb), 1);
    chk("R9 normal evict addr", r_wba, na(4, 2));
    chk("R9 normal evict data", r_wbd, 32'hD2);
    chk("R9 no drop", 32'(r_drop), 0);
    cfg(1, 0, 8'h00);
  endtask

  task automatic t_same_cycle();
    req(2, na(5, 0), 1, 32'hE0, 1, 1, 2, 8'hFF);
    chk("R11 old mask used", 32'(r_alloc), 1);
    chk("R11 old mask way", 32'(r_way), 0);
    req(2, na(5, 1), 1, 32'hE1);
    chk("R11 new mask applies", 32'(r_noalloc), 1);
    cfg(1, 2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_round_robin();
    t_enable();
    t_mask();
    t_empty();
    t_spad_evict();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule